// File: doc/BRIEF.md
# Position Reset Mask Controller

This block sits beside a quadrature position counter and its revolution counter. After any reset-type event (an index edge, a position overflow or a position underflow), it holds off further position resets and revolution up/down counting for a programmed number of position steps. The count it loads comes from a 2-bit setting. Each later step in an unchanged direction uses up one count. When the counter reaches zero, resets take effect again.

The mask is cancelled at once in three cases: the counting direction reverses, the position mode code changes, or the revolution mode code changes. The mask is only active when the revolution mode is "off" (code 0) or "index and wrap" (code 3). In the other two revolution modes it stays idle. The block works the same in every position counting mode.

All pins are single-cycle control strobes and level codes sampled on the rising clock edge. They carry no data stream, so there is no valid/ready handshake and no back-pressure. The neighbouring counters use `inhibit` to gate their reset and revolution actions.

Top module: `step_reset_mask`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `mask_cnt` is 0 and `inhibit` is 0.
- R2: A trigger is `index_evt`, `ovf_evt` or `unf_evt` high. In an enabled revolution mode with no mode change, a trigger loads `mask_cnt` at the next edge from `mask_sel`. The encoding is 2'b00 = 0, 2'b01 = 2, 2'b10 = 4 and 2'b11 = 8.
- R3: A step is `step_up` or `step_dn` high. A step with no trigger and no `dir_flip` lowers a nonzero `mask_cnt` by one. `mask_cnt` never goes below 0, and with no trigger, step, flip or mode change it holds its value.
- R4: `inhibit` is 1 exactly when `mask_cnt` is nonzero.
- R5: `dir_flip` high with no trigger and no mode change clears `mask_cnt` to 0 at the next edge.
- R6: If `pos_mode` or `rev_mode` differs from its value in the previous cycle, `mask_cnt` is cleared to 0 at the next edge, even when a trigger is present. After reset, the previous value of both codes is taken as 0.
- R7: When `rev_mode` is 1 or 2, `mask_cnt` is 0 at the next edge and triggers are ignored.
- R8: A trigger while the mask is active reloads the full count. A trigger takes priority over a step and over `dir_flip` in the same cycle.
- R9: The value of `pos_mode` (0 to 3) has no effect on loading, stepping or clearing; only a change of it matters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_up | input | 1 | Position counted up this cycle |
| step_dn | input | 1 | Position counted down this cycle |
| index_evt | input | 1 | Active index edge detected |
| ovf_evt | input | 1 | Position overflow this cycle |
| unf_evt | input | 1 | Position underflow this cycle |
| dir_flip | input | 1 | Counting direction reversed this cycle |
| mask_sel | input | 2 | Mask length setting |
| pos_mode | input | 2 | Current position counting mode code |
| rev_mode | input | 2 | Current revolution mode code |
| inhibit | output | 1 | Suppress position reset and revolution counting |
| mask_cnt | output | 4 | Remaining masked steps |

## Verification
The hardest case to reach is a retrigger that lands while a mask is already partly used up, in the same cycle as a step or a reversal. A second case is a mode change that coincides with a trigger. Both need several specific strobes aligned in one cycle while the counter is nonzero. Directed sequences set these up explicitly. The random phase then raises trigger and step rates and keeps mode codes mostly stable, so that the counter is often part-way through its count when collisions occur.

// File: rtl/step_mask_pkg.sv
package step_mask_pkg;
  typedef enum logic [1:0] {
    RM_OFF   = 2'd0,
    RM_INDEX = 2'd1,
    RM_WRAP  = 2'd2,
    RM_BOTH  = 2'd3
  } rev_mode_e;

  function automatic logic mask_allowed(input logic [1:0] rm);
    return (rm == RM_OFF) || (rm == RM_BOTH);
  endfunction
endpackage

// File: rtl/mask_len_decode.sv
module mask_len_decode #(
  parameter int unsigned LEN1 = 2,
  parameter int unsigned LEN2 = 4,
  parameter int unsigned LEN3 = 8,
  parameter int unsigned W    = 4
) (
  input  logic [1:0]   sel,
  output logic [W-1:0] len
);
  always_comb begin
    unique case (sel)
      2'd0:    len = '0;
      2'd1:    len = W'(LEN1);
      2'd2:    len = W'(LEN2);
      default: len = W'(LEN3);
    endcase
  end
endmodule

// File: rtl/mask_gate_ctrl.sv
module mask_gate_ctrl
  import step_mask_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pos_mode,
  input  logic [1:0] rev_mode,
  output logic       en,
  output logic       mode_chg
);
  logic [1:0] pm_q, rm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_q <= '0;
      rm_q <= '0;
    end else begin
      pm_q <= pos_mode;
      rm_q <= rev_mode;
    end
  end

  assign en       = mask_allowed(rev_mode);
  assign mode_chg = (pm_q != pos_mode) || (rm_q != rev_mode);
endmodule

// File: rtl/mask_step_counter.sv
module mask_step_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         mode_chg,
  input  logic         flip,
  input  logic         trig,
  input  logic         step,
  input  logic [W-1:0] len,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (!en || mode_chg) cnt <= '0;
    else if (trig)            cnt <= len;
    else if (flip)            cnt <= '0;
    else if (step && cnt != '0) cnt <= cnt - W'(1);
  end

  // R7
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0);
  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode_chg && trig) |=> cnt == $past(len));
  // R5
  flip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode_chg && !trig && flip) |=> cnt == '0);
  // R3
  step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode_chg && !trig && !flip && step && cnt != '0) |=> cnt == $past(cnt) - W'(1));
  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !trig) |=> cnt == '0);
  // R6
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> cnt == '0);
endmodule

// File: rtl/step_reset_mask.sv
module step_reset_mask #(
  parameter int unsigned MASK_LEN1 = 2,
  parameter int unsigned MASK_LEN2 = 4,
  parameter int unsigned MASK_LEN3 = 8,
  localparam int unsigned CNT_W    = $clog2(MASK_LEN3 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             index_evt,
  input  logic             ovf_evt,
  input  logic             unf_evt,
  input  logic             dir_flip,
  input  logic [1:0]       mask_sel,
  input  logic [1:0]       pos_mode,
  input  logic [1:0]       rev_mode,
  output logic             inhibit,
  output logic [CNT_W-1:0] mask_cnt
);
  logic [CNT_W-1:0] len;
  logic             en, mode_chg, trig, step;

  assign trig = index_evt | ovf_evt | unf_evt;
  assign step = step_up | step_dn;

  mask_len_decode #(.LEN1(MASK_LEN1), .LEN2(MASK_LEN2), .LEN3(MASK_LEN3), .W(CNT_W))
    u_dec (.sel(mask_sel), .len(len));

  mask_gate_ctrl u_gate (
    .clk(clk), .rst_n(rst_n), .pos_mode(pos_mode), .rev_mode(rev_mode),
    .en(en), .mode_chg(mode_chg));

  mask_step_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_chg(mode_chg), .flip(dir_flip),
    .trig(trig), .step(step), .len(len), .cnt(mask_cnt));

  assign inhibit = |mask_cnt;

  // R8
  retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode_chg && trig && mask_cnt != '0 && mask_sel != 2'd0) |=> inhibit);
endmodule

// File: tb/test_step_reset_mask.sv
module test_step_reset_mask;
  logic clk = 1'b0, rst_n = 1'b0;
  logic step_up = 0, step_dn = 0, index_evt = 0, ovf_evt = 0, unf_evt = 0, dir_flip = 0;
  logic [1:0] mask_sel = 0, pos_mode = 0, rev_mode = 0;
  logic inhibit;
  logic [3:0] mask_cnt;

  int vectors = 0, fails = 0;
  bit done = 0;
  int exp_cnt = 0;
  logic [1:0] prev_pm = 0, prev_rm = 0;

  always #10 clk = ~clk;

  step_reset_mask i_step_reset_mask (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
    .index_evt(index_evt), .ovf_evt(ovf_evt), .unf_evt(unf_evt), .dir_flip(dir_flip),
    .mask_sel(mask_sel), .pos_mode(pos_mode), .rev_mode(rev_mode),
    .inhibit(inhibit), .mask_cnt(mask_cnt));

  function automatic int sel_len(input logic [1:0] s);
    case (s)
      2'd0: return 0;
      2'd1: return 2;
      2'd2: return 4;
      default: return 8;
    endcase
  endfunction

  task automatic check(input string tag);
    vectors++;
    if (mask_cnt !== 4'(exp_cnt)) begin
      fails++;
      $display("FAIL %s mask_cnt actual=%0d expected=%0d", tag, mask_cnt, exp_cnt);
    end
    vectors++;
    if (inhibit !== (exp_cnt != 0)) begin
      fails++;
      $display("FAIL R4 inhibit actual=%0b expected=%0b", inhibit, exp_cnt != 0);
    end
  endtask

  task automatic cyc(input logic up, dn, idx, ov, un, flp,
                     input logic [1:0] sel, pm, rm, input string force_tag = "");
    string tag;
    bit trig, en, chg;
    @(negedge clk);
    step_up = up; step_dn = dn; index_evt = idx; ovf_evt = ov; unf_evt = un;
    dir_flip = flp; mask_sel = sel; pos_mode = pm; rev_mode = rm;
    trig = idx | ov | un;
    en = (rm == 2'd0) || (rm == 2'd3);
    chg = (pm != prev_pm) || (rm != prev_rm);
    if (!en) begin exp_cnt = 0; tag = "R7"; end
    else if (chg) begin exp_cnt = 0; tag = "R6"; end
    else if (trig) begin tag = (exp_cnt != 0) ? "R8" : "R2"; exp_cnt = sel_len(sel); end
    else if (flp) begin exp_cnt = 0; tag = "R5"; end
    else begin
      if ((up | dn) && exp_cnt != 0) exp_cnt--;
      tag = "R3";
    end
    prev_pm = pm; prev_rm = rm;
    if (force_tag != "") tag = force_tag;
    @(posedge clk);
    #5;
    check(tag);
  endtask

  task automatic idle(input int n, input logic [1:0] pm, rm);
    for (int i = 0; i < n; i++) cyc(0,0,0,0,0,0, 2'd2, pm, rm);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #5; check("R1");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5; check("R1");

    // R2: every setting loads its length
    for (int s = 0; s < 4; s++) begin
      cyc(0,0,1,0,0,0, 2'(s), 0, 0, "R2");
      cyc(0,0,0,0,0,1, 2'(s), 0, 0, "R5");
    end
    // R3: step down to zero and hold there
    cyc(1,0,0,1,0,0, 2'd1, 0, 0, "R2");
    for (int i = 0; i < 4; i++) cyc(0,1,0,0,0,0, 2'd1, 0, 0, "R3");
    idle(2, 0, 0);
    // R8: retrigger mid-mask with step and flip in same cycle
    cyc(0,0,0,0,1,0, 2'd3, 0, 0, "R2");
    cyc(1,0,0,0,0,0, 2'd3, 0, 0, "R3");
    cyc(1,0,1,0,0,1, 2'd2, 0, 0, "R8");
    // R5: flip clears
    cyc(1,0,0,0,0,1, 2'd2, 0, 0, "R5");
    // R6: mode change with trigger clears
    cyc(0,0,1,0,0,0, 2'd3, 0, 3, "R6");
    cyc(0,0,1,0,0,0, 2'd3, 0, 3, "R2");
    cyc(0,0,1,0,0,0, 2'd3, 1, 3, "R6");
    // R9: other position modes behave the same
    for (int p = 1; p < 4; p++) begin
      cyc(0,0,0,0,0,0, 2'd2, 2'(p), 3, "R6");
      cyc(0,0,0,1,0,0, 2'd2, 2'(p), 3, "R9");
      cyc(0,1,0,0,0,0, 2'd2, 2'(p), 3, "R9");
    end
    // R7: revolution modes 1 and 2 idle
    cyc(0,0,1,0,0,0, 2'd3, 3, 1, "R7");
    cyc(0,0,1,0,0,0, 2'd3, 3, 1, "R7");
    cyc(0,0,0,1,0,0, 2'd3, 3, 2, "R7");

    // random phase
    begin
      logic [1:0] pm = 0, rm = 0;
      for (int i = 0; i < 4000; i++) begin
        logic up, dn, idx, ov, un, flp;
        if ($urandom_range(0, 60) == 0) pm = 2'($urandom_range(0, 3));
        if ($urandom_range(0, 80) == 0) rm = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 2))
                                              : (($urandom_range(0, 1) == 0) ? 2'd0 : 2'd3);
        up  = ($urandom_range(0, 2) == 0);
        dn  = !up && ($urandom_range(0, 2) == 0);
        idx = ($urandom_range(0, 9) == 0);
        ov  = ($urandom_range(0, 14) == 0);
        un  = ($urandom_range(0, 14) == 0);
        flp = ($urandom_range(0, 19) == 0);
        cyc(up, dn, idx, ov, un, flp, 2'($urandom_range(0, 3)), pm, rm);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule